// File: doc/BRIEF.md
# Multiphase Sampling TDC Hit Encoder

This block converts the levels of one input signal, captured by a set of evenly phase-shifted sampling flip-flops, into hit timestamps. Every coarse clock cycle it receives one sample per phase, already retimed onto the coarse clock. Bit i of the sample word is phase i, and phase 0 is the earliest in the coarse period. Because the phase samples settle at different moments, the block does not search one raw word for an edge. It forms a realigned window: the late half of the phases from the previous coarse cycle, followed by the early half of the phases from the current cycle. This window is a continuous run of time.

Inside that window the block looks for the first rising edge, meaning a 0 followed by a 1 in adjacent bins. The bin just before the window counts as the left neighbour of the first window bin. The phase index of that first 1 becomes the fine code. It is joined to a free-running coarse counter, and the counter value is taken back by one when the edge lay in the half that came from the previous cycle. The result goes out as a registered timestamp with a one-cycle valid strobe. With the default 8 phases and a 16-bit coarse counter, the timestamp is 19 bits wide: coarse value in the upper 16 bits and fine phase in the lower 3. Its unit is one eighth of a coarse period.

Top module: `tdc_hit_encoder`

## Requirements
- R1: While rst_n is low, hit_valid is 0 and hit_time is 0.
- R2: The window at coarse cycle n is made of phases NUM_PHASES/2..NUM_PHASES-1 of cycle n-1, followed by phases 0..NUM_PHASES/2-1 of cycle n. A 0 at phase 7 of cycle n-1 followed by a 1 at phase 0 of cycle n gives a hit with fine code 0 and coarse value n.
- R3: A rising edge inside the window (a 0 in one bin, a 1 in the next later bin) gives a hit. The fine code (hit_time[2:0]) is the phase index of the 1.
- R4: The last bin of the previous window (phase 3 of cycle n-1) is the left neighbour of the first window bin. A 0 there and a 1 at phase 4 of cycle n-1 gives a hit with fine code 4.
- R5: When a window holds more than one rising edge, only the earliest one is reported.
- R6: hit_time[18:3] is the coarse counter value for the cycle in which the reported phase was sampled. The counter reads n in cycle n, so this is n-1 for fines 4..7 and n for fines 0..3. The full timestamp equals the bin count since the first cycle after reset.
- R7: A window that is all 0, all 1 or contains only falling edges gives no hit.
- R8: hit_valid goes high in the cycle after the samples that complete the window are presented. It lasts one cycle per window, so a level that stays high after an edge gives no further hit.
- R9: The first sample word after reset is not paired with the reset contents, so no hit is reported for the first cycle after reset.
- R10: The coarse counter wraps modulo 2^16, and the coarse correction of R6 wraps with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samples | input | NUM_PHASES | Per-phase samples for this coarse cycle, bit i = phase i |
| hit_valid | output | 1 | One-cycle strobe marking a new timestamp |
| hit_time | output | COARSE_W+log2(NUM_PHASES) | Coarse count in the upper bits, fine phase in the lower bits |

## Verification
The checker re-derives the window from its own delayed copies of the samples. On every cycle it checks the following: the outputs stay quiet in reset; no strobe comes from steady levels or from the first word after reset; a reported hit always has both a 0 and a 1 in its window; and the coarse field matches an independent cycle count, adjusted by the half in which the fine code falls. The bench scenarios are what show the exact fine codes. They cover edges at every phase, edges at the window seam and at the previous-window boundary, first-edge priority with two edges, falling-only windows, and the coarse counter wrap.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int DEF_PHASES   = 8;
    localparam int DEF_COARSE_W = 16;

    function automatic int half_of(input int phases);
        return phases / 2;
    endfunction
endpackage

// File: rtl/tdc_window_align.sv
module tdc_window_align #(
    parameter int NUM_PHASES = tdc_pkg::DEF_PHASES
) (
    input  logic [NUM_PHASES-1:0] cur_smp,
    input  logic [NUM_PHASES-1:0] prev_smp,
    output logic [NUM_PHASES-1:0] window,
    output logic                  lead_bit
);
    localparam int HALF = tdc_pkg::half_of(NUM_PHASES);

    // window bit 0 is the earliest bin in time
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_win
        if (k < HALF) begin : g_late_prev
            assign window[k] = prev_smp[k + HALF];
        end else begin : g_early_cur
            assign window[k] = cur_smp[k - HALF];
        end
    end

    // bin just before the window: final bin of the previous window
    assign lead_bit = prev_smp[HALF-1];
endmodule

// File: rtl/tdc_edge_find.sv
module tdc_edge_find #(
    parameter int NUM_PHASES = tdc_pkg::DEF_PHASES,
    localparam int IDX_W     = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0] window,
    input  logic                  lead_bit,
    output logic                  found,
    output logic [IDX_W-1:0]      pos
);
    logic [NUM_PHASES-1:0] rise;

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_rise
        if (k == 0) begin : g_first
            assign rise[k] = window[k] & ~lead_bit;
        end else begin : g_rest
            assign rise[k] = window[k] & ~window[k-1];
        end
    end

    // lowest index (earliest bin) wins
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int k = NUM_PHASES - 1; k >= 0; k--) begin
            if (rise[k]) begin
                found = 1'b1;
                pos   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/tdc_hit_encoder.sv
module tdc_hit_encoder #(
    parameter int NUM_PHASES = tdc_pkg::DEF_PHASES,
    parameter int COARSE_W   = tdc_pkg::DEF_COARSE_W,
    localparam int FINE_W    = $clog2(NUM_PHASES),
    localparam int TIME_W    = COARSE_W + FINE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] samples,
    output logic                  hit_valid,
    output logic [TIME_W-1:0]     hit_time
);
    localparam int HALF = tdc_pkg::half_of(NUM_PHASES);

    typedef struct packed {
        logic [NUM_PHASES-1:0] prev;
        logic                  primed;
        logic [COARSE_W-1:0]   coarse;
        logic                  hit;
        logic [TIME_W-1:0]     stamp;
    } enc_state_t;

    enc_state_t st_q, st_d;

    logic [NUM_PHASES-1:0] win_c;
    logic                  lead_c;
    logic                  found_c;
    logic [FINE_W-1:0]     pos_c;
    logic [FINE_W-1:0]     fine_c;
    logic                  early_c;
    logic [COARSE_W-1:0]   coarse_sel_c;

    tdc_window_align #(.NUM_PHASES(NUM_PHASES)) u_align (
        .cur_smp  (samples),
        .prev_smp (st_q.prev),
        .window   (win_c),
        .lead_bit (lead_c)
    );

    tdc_edge_find #(.NUM_PHASES(NUM_PHASES)) u_find (
        .window   (win_c),
        .lead_bit (lead_c),
        .found    (found_c),
        .pos      (pos_c)
    );

    always_comb begin
        // window index -> physical phase index (rotate by half)
        fine_c       = pos_c + FINE_W'(HALF);
        early_c      = ~pos_c[FINE_W-1];
        coarse_sel_c = early_c ? (st_q.coarse - COARSE_W'(1)) : st_q.coarse;

        st_d        = st_q;
        st_d.prev   = samples;
        st_d.primed = 1'b1;
        st_d.coarse = st_q.coarse + COARSE_W'(1);
        st_d.hit    = found_c & st_q.primed;
        if (found_c && st_q.primed) begin
            st_d.stamp = {coarse_sel_c, fine_c};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_valid = st_q.hit;
    assign hit_time  = st_q.stamp;
endmodule

// File: rtl/tdc_hit_encoder_chk.sv
module tdc_hit_encoder_chk #(
    parameter int NUM_PHASES = tdc_pkg::DEF_PHASES,
    parameter int COARSE_W   = tdc_pkg::DEF_COARSE_W,
    localparam int FINE_W    = $clog2(NUM_PHASES),
    localparam int TIME_W    = COARSE_W + FINE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PHASES-1:0] samples,
    input logic                  hit_valid,
    input logic [TIME_W-1:0]     hit_time
);
    localparam int HALF = NUM_PHASES / 2;

    logic [NUM_PHASES-1:0] smp_q, smp_qq;
    logic [COARSE_W-1:0]   cyc_q;
    logic [1:0]            age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= '0;
            smp_qq <= '0;
            cyc_q  <= '0;
            age_q  <= '0;
        end else begin
            smp_q  <= samples;
            smp_qq <= smp_q;
            cyc_q  <= cyc_q + COARSE_W'(1);
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!hit_valid && hit_time == '0));

    // R7
    a_r7_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((smp_q == '0 && smp_qq == '0) || (&smp_q && &smp_qq)) |-> !hit_valid);

    // R3
    a_r3_rise_present: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ((|{smp_q[HALF-1:0], smp_qq[NUM_PHASES-1:HALF]}) &&
                       !(&{smp_q[HALF-1:0], smp_qq[NUM_PHASES-1:HALF-1]})));

    // R6
    a_r6_coarse_half: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_time[FINE_W-1]
            ? (hit_time[TIME_W-1:FINE_W] == COARSE_W'(cyc_q - COARSE_W'(2)))
            : (hit_time[TIME_W-1:FINE_W] == COARSE_W'(cyc_q - COARSE_W'(1)))));

    // R9
    a_r9_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd1) |-> !hit_valid);
endmodule

bind tdc_hit_encoder tdc_hit_encoder_chk #(
    .NUM_PHASES (NUM_PHASES),
    .COARSE_W   (COARSE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samples   (samples),
    .hit_valid (hit_valid),
    .hit_time  (hit_time)
);

// File: tb/tb_tdc_hit_encoder.sv
module tb_tdc_hit_encoder;
    localparam int NPH = 8;
    localparam int CW  = 16;
    localparam int TW  = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NPH-1:0] samples = '0;
    logic          hit_valid;
    logic [TW-1:0] hit_time;

    int errors = 0;
    int checks = 0;
    int n = 0;
    logic [NPH-1:0] sprev = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdc_hit_encoder #(.NUM_PHASES(NPH), .COARSE_W(CW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples   (samples),
        .hit_valid (hit_valid),
        .hit_time  (hit_time)
    );

    // timeline model: bins 0..7 = previous word, 8..15 = current word
    function automatic void model(input logic [7:0] cur, input logic [7:0] prv,
                                  input int cyc, output bit v, output int t,
                                  output bit early);
        logic [15:0] str;
        str = {cur, prv};
        v = 1'b0; t = 0; early = 1'b0;
        if (cyc == 0) return;
        for (int j = 4; j < 12; j++) begin
            if (!v && str[j] && !str[j-1]) begin
                v = 1'b1;
                t = ((cyc - 1) * 8 + j) % (1 << TW);
                early = (j < 8);
            end
        end
    endfunction

    function automatic logic [7:0] rand_word();
        int mode;
        mode = $urandom % 5;
        case (mode)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'(8'hFF << ($urandom % 8));
            3: return 8'(8'hFF >> ($urandom % 8));
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic step(input logic [7:0] s, input string tag);
        bit v;
        bit early;
        int t;
        string tg;
        samples = s;
        @(posedge clk);
        #1;
        model(s, sprev, n, v, t, early);
        tg = tag;
        if (tg == "") tg = !v ? "R7" : (early ? "R6" : "R3");
        checks++;
        if (hit_valid !== v || (v && hit_time !== TW'(t))) begin
            errors++;
            $display("FAIL %s cycle %0d: valid=%0b time=%0d expected valid=%0b time=%0d",
                     tg, n, hit_valid, hit_time, v, t);
        end
        sprev = s;
        n++;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", n);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: outputs stay zero in reset while inputs move
        for (int i = 0; i < 3; i++) begin
            samples = (i % 2 == 0) ? 8'h0F : 8'hF0;
            @(posedge clk);
            #1;
            checks++;
            if (hit_valid !== 1'b0 || hit_time !== '0) begin
                errors++;
                $display("FAIL R1 reset: valid=%0b time=%0d expected valid=0 time=0",
                         hit_valid, hit_time);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first word after reset, all ones, must not pair with reset state
        step(8'hFF, "R9");
        step(8'hFF, "R7");
        // R7: falling only
        step(8'h0F, "R7");
        step(8'h00, "R7");
        // R2: seam between previous phase 7 and current phase 0
        step(8'h00, "R2");
        step(8'hFF, "R2");
        // R8: level stays high, no second strobe
        step(8'hFF, "R8");
        step(8'hFF, "R8");
        // R4: boundary bin (prev phase 3 = 0, prev phase 4 = 1)
        step(8'h00, "R4");
        step(8'hF0, "R4");
        step(8'hFF, "R4");
        // R5: two edges, one from the previous half
        step(8'h00, "R5");
        step(8'h20, "R5");
        step(8'h0C, "R5");
        // R5: two edges in the current half
        step(8'h00, "R5");
        step(8'h00, "R5");
        step(8'h05, "R5");
        // R3 / R6: edge at every phase
        for (int p = 0; p < NPH; p++) begin
            step(8'h00, "");
            step(8'h00, "");
            step(8'(8'hFF << p), "");
            step(8'hFF, "");
            step(8'hFF, "R8");
        end
        // random stream up to the coarse wrap
        while (n < 65534) step(rand_word(), "");
        // R10: wrap of the coarse counter
        step(8'h00, "R10");
        step(8'hF0, "R10");
        step(8'hFF, "R10");  // prev-half edge, coarse 65535
        step(8'h00, "R10");
        step(8'hFF, "R10");  // current-half edge, coarse wrapped to 2
        for (int i = 0; i < 200; i++) step(rand_word(), "");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule